// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer

An 8-bit up-counter with two compare constants, a small CPU register window, three event flags with interrupt requests, and one waveform output. A tap select in the control register picks one of seven incoming clock-enable pulse lines (produced by an external prescaler or edge detector), and the counter advances by one on each clock cycle where the selected line is high. Tap select 0 freezes the counter.

On each advance the current count is compared with constant A and constant B. A match sets that constant's flag and can clear the counter, depending on the clear-source field. The counter can also be cleared by a rising edge on an external clear input. Each match can also drive the waveform output low, high or toggled, and A overrides B when both match together. Advancing from 0xFF sets an overflow flag.

Software clears a flag by reading it as 1 and then writing 0 to it. A standby input holds all state at reset values and blocks bus writes.

Top module: `tmr8_top`

## Requirements
- R1: After reset, and on every cycle while `standby_i` is high, the counter reads 0x00, both constants read 0xFF, the control and status registers read 0x00 and `wave_o` is 0. Bus writes have no effect during standby.
- R2: Control bits 2:0 select the tap. Value k in 1..7 advances the counter on cycles where `tick_i[k-1]` is high. Value 0 holds the counter whatever the ticks are.
- R3: An advance taken while the counter holds 0xFF sets the overflow flag (status bit 5).
- R4: An advance taken while the counter equals constant A sets flag A (status bit 6). Equality with constant B sets flag B (status bit 7). Flags update on the same clock edge as the counter.
- R5: Control bits 4:3 pick the clear source: 00 none, 01 match A, 10 match B, 11 external. When the selected match occurs, the counter goes to 0x00 instead of incrementing.
- R6: Status bits 1:0 (for A) and 3:2 (for B) select the output action on a match: 00 keep, 01 drive 0, 10 drive 1, 11 toggle. When both match in one cycle, only the A action applies.
- R7: A flag is cleared by a status write with a 0 in its bit, but only if a status read since the last status write returned that flag as 1. Writing 1 leaves the flag unchanged. A hardware set in the same cycle as the clear wins.
- R8: `irq_cmpb_o`, `irq_cmpa_o` and `irq_ovf_o` equal their flag ANDed with control bits 7, 6 and 5.
- R9: Register map: address 0 control, 1 status, 2 constant A, 3 constant B, 4 counter (read/write, a write overrides any count change in that cycle). Other addresses read 0. Status bit 4 reads 0. Read data is combinational.
- R10: With clear source 11, a 0-to-1 transition of `ext_clr_i` clears the counter on the next edge. A held high level does not clear again. With any other clear source the input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Holds all state at reset values |
| tick_i | input | 7 | Clock-enable pulse taps |
| ext_clr_i | input | 1 | External counter clear, rising edge |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| irq_cmpa_o | output | 1 | Compare A interrupt request |
| irq_cmpb_o | output | 1 | Compare B interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| wave_o | output | 1 | Waveform output |

## Verification
The properties assume that the tick lines and `ext_clr_i` are synchronous to `clk_i`. They also assume each bus access is a single-cycle strobe that is either a read or a write, never both. The bench drives every input on the falling edge, holds each bus strobe for exactly one cycle and raises ticks as level windows a whole number of cycles wide, so every advance, match and clear falls on a known rising edge. In the set-wins case, a status write and an advancing tick deliberately land in the same cycle.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned NUM_TAPS  = 7;
  localparam int unsigned CKS_W     = $clog2(NUM_TAPS + 1);
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_LSB  = 5;

  localparam int unsigned FLG_OVF  = 0;
  localparam int unsigned FLG_CMPA = 1;
  localparam int unsigned FLG_CMPB = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd4;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_CMPA = 2'b01,
    CLR_CMPB = 2'b10,
    CLR_EXT  = 2'b11
  } clr_sel_e;

  typedef enum logic [1:0] {
    OUT_KEEP = 2'b00,
    OUT_LOW  = 2'b01,
    OUT_HIGH = 2'b10,
    OUT_FLIP = 2'b11
  } out_sel_e;

  typedef struct packed {
    logic             ie_b;
    logic             ie_a;
    logic             ie_ovf;
    clr_sel_e         clr_sel;
    logic [CKS_W-1:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                standby_i,
  input  logic [NUM_TAPS-1:0] tick_i,
  input  logic [CKS_W-1:0]    clk_sel_i,
  input  clr_sel_e            clr_sel_i,
  input  logic [REG_W-1:0]    cmp_a_i,
  input  logic [REG_W-1:0]    cmp_b_i,
  input  logic                ext_clr_i,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    cnt_o,
  output logic                adv_o,
  output logic                match_a_o,
  output logic                match_b_o,
  output logic                ovf_o
);
  logic [NUM_TAPS:0] taps;
  logic [REG_W-1:0]  cnt_q;
  logic              ext_q;
  logic              ext_rise;
  logic              clr;

  // tap 0 is tied low: select 0 stops the counter
  assign taps      = {tick_i, 1'b0};
  assign adv_o     = taps[clk_sel_i] & ~standby_i;
  assign match_a_o = adv_o & (cnt_q == cmp_a_i);
  assign match_b_o = adv_o & (cnt_q == cmp_b_i);
  assign ovf_o     = adv_o & (cnt_q == {REG_W{1'b1}});
  assign ext_rise  = ext_clr_i & ~ext_q;

  always_comb begin
    unique case (clr_sel_i)
      CLR_CMPA: clr = match_a_o;
      CLR_CMPB: clr = match_b_o;
      CLR_EXT:  clr = ext_rise;
      default:  clr = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_clr_i;
      if (standby_i)    cnt_q <= '0;
      else if (wr_en_i) cnt_q <= wr_data_i;
      else if (clr)     cnt_q <= '0;
      else if (adv_o)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 standby_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [REG_W-1:0]     bus_wdata_i,
  output logic [REG_W-1:0]     bus_rdata_o,
  input  logic [REG_W-1:0]     cnt_i,
  input  logic [NUM_FLAGS-1:0] evt_i,
  output ctrl_t                ctrl_o,
  output logic [REG_W-1:0]     cmp_a_o,
  output logic [REG_W-1:0]     cmp_b_o,
  output out_sel_e             os_a_o,
  output out_sel_e             os_b_o,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic [NUM_FLAGS-1:0] irq_o,
  output logic                 cnt_we_o
);
  logic                 wr_stb;
  logic                 rd_stb;
  logic                 stat_wr;
  logic                 stat_rd;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] arm_q;
  logic [NUM_FLAGS-1:0] irq_en;

  assign wr_stb   = bus_sel_i & bus_wr_i & ~standby_i;
  assign rd_stb   = bus_sel_i & ~bus_wr_i;
  assign stat_wr  = wr_stb & (bus_addr_i == ADR_STAT);
  assign stat_rd  = rd_stb & (bus_addr_i == ADR_STAT);
  assign cnt_we_o = wr_stb & (bus_addr_i == ADR_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      cmp_a_o <= '1;
      cmp_b_o <= '1;
      os_a_o  <= OUT_KEEP;
      os_b_o  <= OUT_KEEP;
    end else if (standby_i) begin
      ctrl_o  <= '0;
      cmp_a_o <= '1;
      cmp_b_o <= '1;
      os_a_o  <= OUT_KEEP;
      os_b_o  <= OUT_KEEP;
    end else if (wr_stb) begin
      unique case (bus_addr_i)
        ADR_CTRL: ctrl_o  <= ctrl_t'(bus_wdata_i);
        ADR_STAT: begin
          os_a_o <= out_sel_e'(bus_wdata_i[1:0]);
          os_b_o <= out_sel_e'(bus_wdata_i[3:2]);
        end
        ADR_CMPA: cmp_a_o <= bus_wdata_i;
        ADR_CMPB: cmp_b_o <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  // read-1-then-write-0 clear; hardware set takes precedence
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else if (standby_i) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        if (stat_rd && flag_q[i]) arm_q[i] <= 1'b1;
        if (stat_wr)              arm_q[i] <= 1'b0;
        if (evt_i[i])
          flag_q[i] <= 1'b1;
        else if (stat_wr && arm_q[i] && !bus_wdata_i[FLAG_LSB+i])
          flag_q[i] <= 1'b0;
      end
    end
  end

  assign irq_en = {ctrl_o.ie_b, ctrl_o.ie_a, ctrl_o.ie_ovf};
  assign irq_o  = flag_q & irq_en;
  assign flag_o = flag_q;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_stb) begin
      unique case (bus_addr_i)
        ADR_CTRL: bus_rdata_o = ctrl_o;
        ADR_STAT: bus_rdata_o = {flag_q, 1'b0, os_b_o, os_a_o};
        ADR_CMPA: bus_rdata_o = cmp_a_o;
        ADR_CMPB: bus_rdata_o = cmp_b_o;
        ADR_CNT:  bus_rdata_o = cnt_i;
        default:  bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     standby_i,
  input  logic     match_a_i,
  input  logic     match_b_i,
  input  out_sel_e os_a_i,
  input  out_sel_e os_b_i,
  output logic     wave_o
);
  out_sel_e act;
  logic     wave_q;

  // A wins when both match
  always_comb begin
    if (match_a_i)      act = os_a_i;
    else if (match_b_i) act = os_b_i;
    else                act = OUT_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
    end else if (standby_i) begin
      wave_q <= 1'b0;
    end else begin
      unique case (act)
        OUT_LOW:  wave_q <= 1'b0;
        OUT_HIGH: wave_q <= 1'b1;
        OUT_FLIP: wave_q <= ~wave_q;
        default:  wave_q <= wave_q;
      endcase
    end
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
  import tmr8_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                standby_i,
  input  logic [NUM_TAPS-1:0] tick_i,
  input  logic                ext_clr_i,
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  output logic                irq_cmpa_o,
  output logic                irq_cmpb_o,
  output logic                irq_ovf_o,
  output logic                wave_o
);
  ctrl_t                ctrl;
  logic [REG_W-1:0]     cmp_a;
  logic [REG_W-1:0]     cmp_b;
  logic [REG_W-1:0]     cnt;
  out_sel_e             os_a;
  out_sel_e             os_b;
  logic                 adv;
  logic                 match_a;
  logic                 match_b;
  logic                 ovf;
  logic                 cnt_we;
  logic [NUM_FLAGS-1:0] evt;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] irq;

  assign evt = {match_b, match_a, ovf};

  tmr8_counter u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .standby_i (standby_i),
    .tick_i    (tick_i),
    .clk_sel_i (ctrl.clk_sel),
    .clr_sel_i (ctrl.clr_sel),
    .cmp_a_i   (cmp_a),
    .cmp_b_i   (cmp_b),
    .ext_clr_i (ext_clr_i),
    .wr_en_i   (cnt_we),
    .wr_data_i (bus_wdata_i),
    .cnt_o     (cnt),
    .adv_o     (adv),
    .match_a_o (match_a),
    .match_b_o (match_b),
    .ovf_o     (ovf)
  );

  tmr8_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .standby_i   (standby_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cnt_i       (cnt),
    .evt_i       (evt),
    .ctrl_o      (ctrl),
    .cmp_a_o     (cmp_a),
    .cmp_b_o     (cmp_b),
    .os_a_o      (os_a),
    .os_b_o      (os_b),
    .flag_o      (flags),
    .irq_o       (irq),
    .cnt_we_o    (cnt_we)
  );

  tmr8_wave u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .standby_i (standby_i),
    .match_a_i (match_a),
    .match_b_i (match_b),
    .os_a_i    (os_a),
    .os_b_i    (os_b),
    .wave_o    (wave_o)
  );

  assign irq_ovf_o  = irq[FLG_OVF];
  assign irq_cmpa_o = irq[FLG_CMPA];
  assign irq_cmpb_o = irq[FLG_CMPB];
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
  import tmr8_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 standby_i,
  input logic [REG_W-1:0]     cnt,
  input logic [REG_W-1:0]     cmp_a,
  input logic [REG_W-1:0]     cmp_b,
  input logic [REG_W-1:0]     ctrl_raw,
  input logic                 adv,
  input logic                 match_a,
  input logic                 match_b,
  input logic                 cnt_we,
  input logic [NUM_FLAGS-1:0] flags,
  input logic                 irq_cmpa_o,
  input logic                 wave_o
);
  p_standby_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (cnt == '0 && cmp_a == '1 && cmp_b == '1 && ctrl_raw == '0 && !wave_o));

  p_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_raw[2:0] == '0 && ctrl_raw[4:3] != 2'b11 && !cnt_we && !standby_i) |=> $stable(cnt));

  p_ovf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && cnt == '1 && !standby_i) |=> flags[FLG_OVF]);

  p_cmfa_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_a && !standby_i) |=> flags[FLG_CMPA]);

  p_cmfb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_b && !standby_i) |=> flags[FLG_CMPB]);

  p_wave_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_a && !match_b && !standby_i) |=> $stable(wave_o));

  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cmpa_o |-> (flags[FLG_CMPA] && ctrl_raw[6]));
endmodule

bind tmr8_top tmr8_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .standby_i  (standby_i),
  .cnt        (cnt),
  .cmp_a      (cmp_a),
  .cmp_b      (cmp_b),
  .ctrl_raw   (ctrl),
  .adv        (adv),
  .match_a    (match_a),
  .match_b    (match_b),
  .cnt_we     (cnt_we),
  .flags      (flags),
  .irq_cmpa_o (irq_cmpa_o),
  .wave_o     (wave_o)
);

// File: tb/tmr8_top_tb_top.sv
module tmr8_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic [6:0] tick = '0;
  logic       ext_clr = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_a, irq_b, irq_o;
  logic       wave;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tmr8_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .standby_i   (standby),
    .tick_i      (tick),
    .ext_clr_i   (ext_clr),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_cmpa_o  (irq_a),
    .irq_cmpb_o  (irq_b),
    .irq_ovf_o   (irq_o),
    .wave_o      (wave)
  );

  typedef struct packed {
    logic [7:0]  cmpa;
    logic [7:0]  cmpb;
    logic [7:0]  ctrl;
    logic [7:0]  stat;
    logic [6:0]  mask;
    logic [15:0] n;
    logic [7:0]  exp_cnt;
    logic [2:0]  exp_flg;
    logic        exp_wave;
  } vec_t;

  // flags = {B, A, ovf}
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 8'hFF, 8'h01, 8'h00, 7'h01, 16'd5,   8'h05, 3'b000, 1'b0}, // R2 plain count
    '{8'h03, 8'hFF, 8'h09, 8'h03, 7'h01, 16'd10,  8'h02, 3'b010, 1'b0}, // R5 clr A, R6 toggle
    '{8'hFF, 8'h02, 8'h11, 8'h08, 7'h01, 16'd7,   8'h01, 3'b100, 1'b1}, // R5 clr B, R6 set
    '{8'h10, 8'h20, 8'h01, 8'h06, 7'h01, 16'd280, 8'h18, 3'b111, 1'b1}, // R3 wrap, R4
    '{8'hFF, 8'hFF, 8'h03, 8'h00, 7'h02, 16'd5,   8'h00, 3'b000, 1'b0}, // R2 wrong tap
    '{8'hFF, 8'hFF, 8'h00, 8'h00, 7'h7F, 16'd5,   8'h00, 3'b000, 1'b0}, // R2 select 0
    '{8'hFF, 8'hFF, 8'h07, 8'h00, 7'h40, 16'd9,   8'h09, 3'b000, 1'b0}, // R2 top tap
    '{8'h04, 8'h04, 8'h01, 8'h06, 7'h01, 16'd5,   8'h05, 3'b110, 1'b1}, // R6 A priority
    '{8'h00, 8'hFF, 8'h09, 8'h03, 7'h01, 16'd4,   8'h00, 3'b010, 1'b0}  // R5 match at 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic run_ticks(input logic [6:0] m, input int n);
    @(negedge clk);
    tick = m;
    repeat (n) @(negedge clk);
    tick = '0;
  endtask

  task automatic stby_pulse();
    @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    bus_rd(3'd0, d); check("R1 ctrl", d, 8'h00);
    bus_rd(3'd1, d); check("R1 stat", d, 8'h00);
    bus_rd(3'd2, d); check("R1 cmpa", d, 8'hFF);
    bus_rd(3'd3, d); check("R1 cmpb", d, 8'hFF);
    bus_rd(3'd4, d); check("R1 cnt", d, 8'h00);
    check("R1 wave", wave, 1'b0);
    check("R1 irq", {irq_b, irq_a, irq_o}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      stby_pulse();
      bus_wr(3'd2, VECS[i].cmpa);
      bus_wr(3'd3, VECS[i].cmpb);
      bus_wr(3'd1, VECS[i].stat);
      bus_wr(3'd0, VECS[i].ctrl);
      run_ticks(VECS[i].mask, int'(VECS[i].n));
      bus_rd(3'd4, d);
      check($sformatf("R2/R5 vec%0d cnt", i), d, VECS[i].exp_cnt);
      bus_rd(3'd1, d);
      check($sformatf("R3/R4 vec%0d flags", i), d[7:5], VECS[i].exp_flg);
      check($sformatf("R6 vec%0d wave", i), wave, VECS[i].exp_wave);
    end

    // R7 clear protocol
    stby_pulse();
    bus_wr(3'd2, 8'h02);
    bus_wr(3'd0, 8'h01);
    run_ticks(7'h01, 3);
    bus_wr(3'd1, 8'h00);
    bus_rd(3'd1, d); check("R7 no clear without read", d, 8'h40);
    bus_wr(3'd1, 8'h00);
    bus_rd(3'd1, d); check("R7 clear after read", d, 8'h00);

    // R7 set wins over clear
    bus_wr(3'd4, 8'h02);
    run_ticks(7'h01, 1);
    bus_rd(3'd1, d);
    bus_wr(3'd4, 8'h02);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 3'd1; wdata = 8'h00; tick = 7'h01;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; tick = '0;
    bus_rd(3'd1, d); check("R7 set wins", d, 8'h40);
    bus_rd(3'd4, d); check("R9 cnt after match", d, 8'h03);

    // R8 interrupt gating
    bus_wr(3'd0, 8'h40);
    #1 check("R8 irq a enabled", {irq_b, irq_a, irq_o}, 3'b010);
    bus_wr(3'd0, 8'h20);
    #1 check("R8 irq a masked", {irq_b, irq_a, irq_o}, 3'b000);

    // R7 writing 1 keeps the flag
    bus_rd(3'd1, d);
    bus_wr(3'd1, 8'hE0);
    bus_rd(3'd1, d); check("R7 write one keeps", d, 8'h40);

    // R10 external clear
    stby_pulse();
    bus_wr(3'd0, 8'h19);
    run_ticks(7'h01, 5);
    @(negedge clk); ext_clr = 1'b1;
    bus_rd(3'd4, d); check("R10 rise clears", d, 8'h00);
    run_ticks(7'h01, 3);
    bus_rd(3'd4, d); check("R10 level no clear", d, 8'h03);
    ext_clr = 1'b0;
    bus_wr(3'd0, 8'h01);
    @(negedge clk); ext_clr = 1'b1;
    bus_rd(3'd4, d); check("R10 ignored when not selected", d, 8'h03);
    ext_clr = 1'b0;

    // R9 map
    bus_wr(3'd4, 8'h7E);
    bus_rd(3'd4, d); check("R9 cnt write", d, 8'h7E);
    bus_wr(3'd3, 8'h5A);
    bus_rd(3'd3, d); check("R9 cmpb rw", d, 8'h5A);
    bus_rd(3'd5, d); check("R9 unmapped", d, 8'h00);
    bus_wr(3'd1, 8'hFF);
    bus_rd(3'd1, d); check("R9 stat bit4", d[4], 1'b0);

    // R1 standby
    bus_wr(3'd0, 8'hE1);
    bus_wr(3'd2, 8'h33);
    @(negedge clk); standby = 1'b1; tick = 7'h7F;
    bus_wr(3'd0, 8'h55);
    bus_wr(3'd2, 8'h11);
    bus_rd(3'd0, d); check("R1 standby ctrl", d, 8'h00);
    bus_rd(3'd4, d); check("R1 standby cnt", d, 8'h00);
    @(negedge clk); standby = 1'b0; tick = '0;
    bus_rd(3'd2, d); check("R1 cmpa after standby", d, 8'hFF);
    bus_rd(3'd0, d); check("R1 ctrl after standby", d, 8'h00);
    check("R1 wave after standby", wave, 1'b0);

    finish_run();
  end
endmodule